// File: doc/BRIEF.md
# Bidirectional Linear Sweep Generator

This block produces a ramp of a tuning word whose direction and progress are steered at run time. It holds its position between a lower and an upper bound. Each direction has its own step size and its own step interval. The interval is a count of clocks between updates. A live direction input selects climbing or descending. A live hold input freezes the ramp together with its interval timer. A clear input reloads the ramp with the lower bound. The ramp saturates at whichever bound it meets and never wraps past it. A single flag reports that the ramp sits on either bound.

The ramp word is routed to one of three accumulator inputs (frequency, phase or amplitude) by a 2-bit destination code. The outputs that are not selected carry zero. All control inputs are sampled on the rising clock edge. The limits are expected to satisfy lower <= upper.

Top module: `lin_sweep_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the ramp output is 0 and no destination output is non-zero.
- R2: With dir_up high and hold low, the ramp rises by step_up once every ivl_up+1 clocks. After a clear, the first rise comes on the ivl_up+1-th clock edge.
- R3: With dir_up low and hold low, the ramp falls by step_dn once every ivl_dn+1 clocks.
- R4: A rising step that would pass hi_lim, or that would pass 2^32-1, leaves the ramp at exactly hi_lim. The ramp never wraps.
- R5: A falling step that would go below lo_lim, or below zero, leaves the ramp at exactly lo_lim.
- R6: While hold is high and clr is low, the ramp keeps its value and the interval timer keeps its count. After hold falls, the count resumes where it stopped.
- R7: at_limit is 1 on every cycle in which the ramp equals lo_lim or hi_lim. It returns to 0 on the first clock after the ramp leaves that value.
- R8: A clr sampled high loads lo_lim into the ramp on that edge and restarts the interval timer. This takes priority over hold and direction.
- R9: Destination code 00 routes the ramp to freq_word, 01 to phase_word and 10 to amp_word. Code 11 routes it nowhere. Outputs that are not selected are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Load the lower bound and restart the timer |
| dir_up | input | 1 | 1 = climb, 0 = descend |
| hold | input | 1 | Freeze the ramp and the timer |
| lo_lim | input | 32 | Lower bound |
| hi_lim | input | 32 | Upper bound |
| step_up | input | 32 | Increment per rising update |
| step_dn | input | 32 | Decrement per falling update |
| ivl_up | input | 16 | Clocks between rising updates, minus one |
| ivl_dn | input | 16 | Clocks between falling updates, minus one |
| dest_sel | input | 2 | Destination code |
| ramp | output | 32 | Present ramp value |
| at_limit | output | 1 | Ramp sits on a bound |
| freq_word | output | 32 | Frequency destination |
| phase_word | output | 32 | Phase destination |
| amp_word | output | 32 | Amplitude destination |

## Verification
The bound checker watches every cycle for several behaviours. It checks that the ramp stays still under hold. It checks that a clear lands on the lower bound. It checks that a climb never decreases the ramp or passes the upper bound, and that a descent never increases it or drops below the lower bound. It also checks that the flag is only raised on a bound and that at most one destination carries a value. Only the directed scenarios can show the exact step spacing set by each interval, the exact saturation values at the 32-bit edge, the flag falling on the clock after departure, and the timer resuming mid-count after a hold.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
   typedef enum logic [1:0] {
      DEST_FREQ  = 2'b00,
      DEST_PHASE = 2'b01,
      DEST_AMP   = 2'b10,
      DEST_NONE  = 2'b11
   } dest_e;

   localparam int unsigned N_DEST = 3;
endpackage

// File: rtl/sweep_interval_timer.sv
module sweep_interval_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [CNT_W-1:0] span,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_q;

   initial begin
      if (CNT_W < 1) $error("CNT_W must be at least 1");
   end

   assign fire = run && !restart && (cnt_q >= span);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (fire)       cnt_q <= '0;
      else if (run)        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sweep_accum.sv
module sweep_accum #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         fire,
   input  logic         dir_up,
   input  logic [W-1:0] lo_lim,
   input  logic [W-1:0] hi_lim,
   input  logic [W-1:0] step_up,
   input  logic [W-1:0] step_dn,
   output logic [W-1:0] acc_q,
   output logic [W-1:0] acc_next
);
   logic [W:0] sum_w;
   logic [W:0] dif_w;
   logic [W-1:0] up_val;
   logic [W-1:0] dn_val;

   initial begin
      if (W < 8) $error("W must be at least 8");
   end

   assign sum_w = {1'b0, acc_q} + {1'b0, step_up};
   assign dif_w = {1'b0, acc_q} - {1'b0, step_dn};

   always_comb begin
      if (sum_w[W] || (sum_w[W-1:0] > hi_lim)) up_val = hi_lim;
      else                                     up_val = sum_w[W-1:0];
      if (dif_w[W] || (dif_w[W-1:0] < lo_lim)) dn_val = lo_lim;
      else                                     dn_val = dif_w[W-1:0];
   end

   always_comb begin
      if (clr)       acc_next = lo_lim;
      else if (fire) acc_next = dir_up ? up_val : dn_val;
      else           acc_next = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_next;
   end
endmodule

// File: rtl/sweep_limit_flag.sv
module sweep_limit_flag #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] nxt,
   input  logic [W-1:0] lo_lim,
   input  logic [W-1:0] hi_lim,
   output logic         hit_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= (nxt == lo_lim) || (nxt == hi_lim);
   end
endmodule

// File: rtl/lin_sweep_gen.sv
module lin_sweep_gen
   import sweep_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             dir_up,
   input  logic             hold,
   input  logic [W-1:0]     lo_lim,
   input  logic [W-1:0]     hi_lim,
   input  logic [W-1:0]     step_up,
   input  logic [W-1:0]     step_dn,
   input  logic [CNT_W-1:0] ivl_up,
   input  logic [CNT_W-1:0] ivl_dn,
   input  logic [1:0]       dest_sel,
   output logic [W-1:0]     ramp,
   output logic             at_limit,
   output logic [W-1:0]     freq_word,
   output logic [W-1:0]     phase_word,
   output logic [W-1:0]     amp_word
);
   logic             fire;
   logic [CNT_W-1:0] span;
   logic [W-1:0]     acc_next;
   logic [W-1:0]     dest_bus [N_DEST];

   assign span = dir_up ? ivl_up : ivl_dn;

   sweep_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(clr), .run(!hold),
      .span(span), .fire(fire)
   );

   sweep_accum #(.W(W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire), .dir_up(dir_up),
      .lo_lim(lo_lim), .hi_lim(hi_lim), .step_up(step_up), .step_dn(step_dn),
      .acc_q(ramp), .acc_next(acc_next)
   );

   sweep_limit_flag #(.W(W)) u_flag (
      .clk(clk), .rst_n(rst_n), .nxt(acc_next),
      .lo_lim(lo_lim), .hi_lim(hi_lim), .hit_q(at_limit)
   );

   for (genvar g = 0; g < N_DEST; g++) begin : g_dest
      assign dest_bus[g] = (dest_sel == 2'(g)) ? ramp : '0;
   end

   assign freq_word  = dest_bus[DEST_FREQ];
   assign phase_word = dest_bus[DEST_PHASE];
   assign amp_word   = dest_bus[DEST_AMP];
endmodule

// File: rtl/lin_sweep_chk.sv
module lin_sweep_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic         dir_up,
   input logic         hold,
   input logic [W-1:0] lo_lim,
   input logic [W-1:0] hi_lim,
   input logic [W-1:0] ramp,
   input logic         at_limit,
   input logic [W-1:0] freq_word,
   input logic [W-1:0] phase_word,
   input logic [W-1:0] amp_word
);
   p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> $stable(ramp));

   p_clear_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ramp == $past(lo_lim)));

   p_climb_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && dir_up && (ramp <= hi_lim)) |=>
      ((ramp >= $past(ramp)) && (ramp <= $past(hi_lim))));

   p_fall_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && !dir_up && (ramp >= lo_lim)) |=>
      ((ramp <= $past(ramp)) && (ramp >= $past(lo_lim))));

   p_flag_on_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      at_limit |-> ((ramp == $past(lo_lim)) || (ramp == $past(hi_lim))));

   p_one_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({freq_word != '0, phase_word != '0, amp_word != '0}));
endmodule

bind lin_sweep_gen lin_sweep_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .dir_up(dir_up), .hold(hold),
   .lo_lim(lo_lim), .hi_lim(hi_lim), .ramp(ramp), .at_limit(at_limit),
   .freq_word(freq_word), .phase_word(phase_word), .amp_word(amp_word)
);

// File: tb/tb_lin_sweep_gen.sv
`timescale 1ns/1ps
module tb_lin_sweep_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0, dir_up = 1'b1, hold = 1'b0;
   logic [31:0] lo_lim = '0, hi_lim = '0, step_up = '0, step_dn = '0;
   logic [15:0] ivl_up = '0, ivl_dn = '0;
   logic [1:0]  dest_sel = 2'b11;
   logic [31:0] ramp, freq_word, phase_word, amp_word;
   logic        at_limit;
   int n_chk = 0, n_bad = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   lin_sweep_gen dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .dir_up(dir_up), .hold(hold),
      .lo_lim(lo_lim), .hi_lim(hi_lim), .step_up(step_up), .step_dn(step_dn),
      .ivl_up(ivl_up), .ivl_dn(ivl_dn), .dest_sel(dest_sel),
      .ramp(ramp), .at_limit(at_limit), .freq_word(freq_word),
      .phase_word(phase_word), .amp_word(amp_word)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_clear();
      clr = 1'b1;
      edges(1);
      clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ramp in reset", ramp, 32'd0);
      check("R1 flag in reset", {31'd0, at_limit}, 32'd0);
      dest_sel = 2'b00;
      #1;
      check("R1 freq_word in reset", freq_word, 32'd0);
      dest_sel = 2'b11;
      rst_n = 1'b1;
      hold = 1'b1;
      edges(1);
      check("R1 ramp after reset", ramp, 32'd0);
   endtask

   task automatic t_climb();
      lo_lim = 32'd100; hi_lim = 32'd1000; step_up = 32'd10; ivl_up = 16'd2;
      dir_up = 1'b1; hold = 1'b0;
      do_clear();
      check("R8 clear loads lo", ramp, 32'd100);
      check("R7 flag at lo", {31'd0, at_limit}, 32'd1);
      edges(2);
      check("R2 no step before interval", ramp, 32'd100);
      edges(1);
      check("R2 first step", ramp, 32'd110);
      check("R7 flag clears after leaving", {31'd0, at_limit}, 32'd0);
      edges(3);
      check("R2 second step", ramp, 32'd120);
      edges(2);
      check("R2 mid interval", ramp, 32'd120);
   endtask

   task automatic t_hold();
      hold = 1'b1;
      edges(5);
      check("R6 held ramp", ramp, 32'd120);
      hold = 1'b0;
      edges(1);
      check("R6 timer resumes mid count", ramp, 32'd130);
      hold = 1'b1; clr = 1'b1;
      edges(1);
      clr = 1'b0;
      check("R8 clear beats hold", ramp, 32'd100);
      hold = 1'b0;
   endtask

   task automatic t_top_sat();
      lo_lim = 32'd990; hi_lim = 32'd1000; step_up = 32'd7; ivl_up = 16'd0;
      do_clear();
      edges(1);
      check("R4 step below hi", ramp, 32'd997);
      check("R7 flag off inside", {31'd0, at_limit}, 32'd0);
      edges(1);
      check("R4 clamp at hi", ramp, 32'd1000);
      check("R7 flag at hi", {31'd0, at_limit}, 32'd1);
      edges(3);
      check("R4 stays at hi", ramp, 32'd1000);
      lo_lim = 32'hFFFF_FF00; hi_lim = 32'hFFFF_FFFF; step_up = 32'h80;
      do_clear();
      edges(2);
      check("R4 approach top", ramp, 32'hFFFF_FFFF);
      edges(1);
      check("R4 no wrap at 2^32", ramp, 32'hFFFF_FFFF);
   endtask

   task automatic t_fall();
      lo_lim = 32'd0; hi_lim = 32'd50; step_up = 32'd50; ivl_up = 16'd0;
      step_dn = 32'd7; ivl_dn = 16'd1; dir_up = 1'b1;
      do_clear();
      edges(1);
      check("R2 jump to hi", ramp, 32'd50);
      dir_up = 1'b0;
      edges(1);
      check("R3 wait interval", ramp, 32'd50);
      edges(1);
      check("R3 first fall", ramp, 32'd43);
      edges(12);
      check("R3 after six falls", ramp, 32'd1);
      check("R7 flag off near lo", {31'd0, at_limit}, 32'd0);
      edges(2);
      check("R5 clamp below zero", ramp, 32'd0);
      check("R7 flag at lo after fall", {31'd0, at_limit}, 32'd1);
      lo_lim = 32'd20; step_dn = 32'd15; hi_lim = 32'd40; dir_up = 1'b1;
      step_up = 32'd40;
      edges(1);
      check("R4 climb to new hi", ramp, 32'd40);
      dir_up = 1'b0; ivl_dn = 16'd0;
      edges(1);
      check("R3 fall by step", ramp, 32'd25);
      edges(1);
      check("R5 clamp at lo", ramp, 32'd20);
   endtask

   task automatic t_dest();
      dest_sel = 2'b00; #1;
      check("R9 freq selected", freq_word, ramp);
      check("R9 phase idle", phase_word, 32'd0);
      dest_sel = 2'b01; #1;
      check("R9 phase selected", phase_word, ramp);
      check("R9 freq idle", freq_word, 32'd0);
      dest_sel = 2'b10; #1;
      check("R9 amp selected", amp_word, ramp);
      check("R9 phase idle amp", phase_word, 32'd0);
      dest_sel = 2'b11; #1;
      check("R9 none freq", freq_word, 32'd0);
      check("R9 none amp", amp_word, 32'd0);
   endtask

   initial begin
      #1;
      edges(2);
      t_reset();
      t_climb();
      t_hold();
      t_top_sat();
      t_fall();
      t_dest();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule